// File: doc/BRIEF.md
# Molecule Configuration Store with Per-Block Serial Rewrite

This block holds the configuration of one logic molecule in a cellular fabric. The 76-bit word is split into five blocks. The mode field is 4 bits. The lookup-table contents field is 16 bits, and the lookup-table input selection field is 16 bits. The switch-box routing field is 24 bits, and a general field of 16 bits holds everything else, including spare bits that can carry genome data. Two serial paths fill the word. The first is a global chain that threads through every molecule of the array and rewrites the whole word. The second is a local port that a neighbouring molecule drives. It rewrites one chosen block and leaves the other four untouched.

Both paths write a shadow copy. The parallel fields that the molecule logic uses change only on a commit pulse, so the molecule never runs on a half-loaded block. During a local rewrite, each bit that leaves the chosen block comes back on a read-back line. A neighbour can therefore read a block by shifting it out, and it can restore the block by shifting the same bits back in.

Top module: `molecule_cfg_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the shadow word, all parallel fields and `nb_dout` become zero. No block stays selected, and `chain_out` reads 0 after that edge.
- R2: On an edge with `chain_en` high, the shadow word `{mode, lut, lutin, swbox, misc}` (76 bits, mode at the top) shifts up by one place. `chain_in` enters bit 0, the LSB of the misc field. `chain_out` always shows bit 75, the MSB of the mode field. After 76 shifts, the first bit sent sits in bit 75.
- R3: The parallel outputs take the shadow word on an edge with `commit` high, and the new values are visible after that edge. With `commit` low, the parallel outputs hold.
- R4: An edge with `nb_sel_load` high and `nb_sel` from 0 to 4 latches that block as the target. The codes are 0 mode, 1 lut, 2 lutin, 3 swbox and 4 misc.
- R5: A `nb_sel_load` with `nb_sel` from 5 to 7 is ignored, and the block selected earlier stays selected.
- R6: Before any valid select has been latched after reset, `nb_strobe` changes neither the shadow word nor `nb_dout`.
- R7: An edge with `nb_strobe` high, a block selected and `chain_en` low shifts only the selected block up by one place, MSB first. `nb_din` enters the block's LSB. The target is the select latched on an earlier edge.
- R8: On such an accepted strobe, `nb_dout` takes the selected block's MSB from before the shift. `nb_dout` holds at every other edge.
- R9: When `chain_en` and `nb_strobe` are high on the same edge, the chain shift happens and the strobe is dropped. The selected block is not shifted a second time, and `nb_dout` holds.
- R10: A commit on the same edge as a chain or local shift transfers the shadow contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_en | input | 1 | Shift the whole word one place along the global chain |
| chain_in | input | 1 | Serial data from the previous molecule in the chain |
| chain_out | output | 1 | Serial data to the next molecule in the chain |
| nb_sel_load | input | 1 | Latch `nb_sel` as the target block |
| nb_sel | input | 3 | Block code, 0 to 4 valid |
| nb_strobe | input | 1 | Shift one bit into the selected block |
| nb_din | input | 1 | Serial data from the neighbour |
| nb_dout | output | 1 | Read-back bit shifted out of the selected block |
| commit | input | 1 | Copy the shadow word to the parallel fields |
| cfg_mode | output | 4 | Active mode field |
| cfg_lut | output | 16 | Active lookup-table contents |
| cfg_lutin | output | 16 | Active lookup-table input selection |
| cfg_swbox | output | 24 | Active switch-box routing |
| cfg_misc | output | 16 | Active general field, spare bits usable for genome |

## Verification
Every result is due one edge after the stimulus that causes it. A shifted shadow bit shows on `chain_out` right after the shifting edge. A read-back bit lands on `nb_dout` after the strobe edge. The parallel fields change after the commit edge. The bench drives all inputs on the falling edge and lets exactly one rising edge pass. It then compares the three outputs, at the next falling edge, with a bench model that it has updated by the requirement rules. A commit placed on the same edge as a shift therefore checks that the contents from before the shift reach the outputs.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int NBLK  = 5;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    BLK_MODE  = 3'd0,
    BLK_LUT   = 3'd1,
    BLK_LUTIN = 3'd2,
    BLK_SWBOX = 3'd3,
    BLK_MISC  = 3'd4
  } blk_e;
endpackage

// File: rtl/mcr_seg.sv
// One configuration block: a shift register fed either by the global chain
// or by the neighbour port; chain has precedence.
module mcr_seg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_chain,
  input  logic         chain_bit,
  input  logic         shift_part,
  input  logic         part_bit,
  output logic [W-1:0] q,
  output logic         msb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift_chain) begin
      q <= {q[W-2:0], chain_bit};
    end else if (shift_part) begin
      q <= {q[W-2:0], part_bit};
    end
  end

  assign msb = q[W-1];
endmodule

// File: rtl/mcr_sel.sv
// Target-block latch for the neighbour port; out-of-range codes are dropped.
module mcr_sel
  import mcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_q,
  output logic             sel_ok
);
  logic in_range;
  assign in_range = (sel_in < SEL_W'(NBLK));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      sel_ok <= 1'b0;
    end else if (load && in_range) begin
      sel_q  <= sel_in;
      sel_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/mcr_active.sv
// Committed copy of the shadow word that drives the molecule logic.
module mcr_active #(
  parameter int TOTAL = 76
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [TOTAL-1:0] d,
  output logic [TOTAL-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (commit) begin
      q <= d;
    end
  end
endmodule

// File: rtl/molecule_cfg_reg.sv
module molecule_cfg_reg
  import mcr_pkg::*;
#(
  parameter int MODE_W  = 4,
  parameter int LUT_W   = 16,
  parameter int LUTIN_W = 16,
  parameter int SWB_W   = 24,
  parameter int MISC_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chain_en,
  input  logic               chain_in,
  output logic               chain_out,
  input  logic               nb_sel_load,
  input  logic [SEL_W-1:0]   nb_sel,
  input  logic               nb_strobe,
  input  logic               nb_din,
  output logic               nb_dout,
  input  logic               commit,
  output logic [MODE_W-1:0]  cfg_mode,
  output logic [LUT_W-1:0]   cfg_lut,
  output logic [LUTIN_W-1:0] cfg_lutin,
  output logic [SWB_W-1:0]   cfg_swbox,
  output logic [MISC_W-1:0]  cfg_misc
);
  localparam int BW [NBLK] = '{MODE_W, LUT_W, LUTIN_W, SWB_W, MISC_W};
  localparam int TOTAL = MODE_W + LUT_W + LUTIN_W + SWB_W + MISC_W;

  // Bit offset of block i inside the word; block 0 sits at the top.
  function automatic int ofs_of(input int i);
    int s;
    s = 0;
    for (int j = i + 1; j < NBLK; j++) s += BW[j];
    return s;
  endfunction

  logic [TOTAL-1:0] shadow;
  logic [TOTAL-1:0] active_q;
  logic [NBLK-1:0]  seg_msb;
  logic [NBLK-1:0]  part_hit;
  logic [SEL_W-1:0] sel_q;
  logic             sel_ok;
  logic             part_go;

  mcr_sel u_sel (
    .clk    (clk),
    .rst    (rst),
    .load   (nb_sel_load),
    .sel_in (nb_sel),
    .sel_q  (sel_q),
    .sel_ok (sel_ok)
  );

  // A strobe is taken only with a valid target and no chain shift pending.
  assign part_go = nb_strobe && sel_ok && !chain_en;

  for (genvar i = 0; i < NBLK; i++) begin : g_seg
    localparam int W  = BW[i];
    localparam int LO = ofs_of(i);
    logic [W-1:0] q;
    logic         cbit;

    // The chain enters the lowest block and rises through the word.
    if (i == NBLK - 1) begin : g_head
      assign cbit = chain_in;
    end else begin : g_link
      assign cbit = seg_msb[i+1];
    end

    assign part_hit[i] = part_go && (sel_q == SEL_W'(i));

    mcr_seg #(.W(W)) u_seg (
      .clk         (clk),
      .rst         (rst),
      .shift_chain (chain_en),
      .chain_bit   (cbit),
      .shift_part  (part_hit[i]),
      .part_bit    (nb_din),
      .q           (q),
      .msb         (seg_msb[i])
    );

    assign shadow[LO+W-1:LO] = q;
  end

  assign chain_out = shadow[TOTAL-1];

  // Read-back: bit leaving the selected block, held between strobes.
  always_ff @(posedge clk) begin
    if (rst) begin
      nb_dout <= 1'b0;
    end else if (|part_hit) begin
      nb_dout <= |(seg_msb & part_hit);
    end
  end

  mcr_active #(.TOTAL(TOTAL)) u_active (
    .clk    (clk),
    .rst    (rst),
    .commit (commit),
    .d      (shadow),
    .q      (active_q)
  );

  assign cfg_mode  = active_q[ofs_of(0)+MODE_W-1  : ofs_of(0)];
  assign cfg_lut   = active_q[ofs_of(1)+LUT_W-1   : ofs_of(1)];
  assign cfg_lutin = active_q[ofs_of(2)+LUTIN_W-1 : ofs_of(2)];
  assign cfg_swbox = active_q[ofs_of(3)+SWB_W-1   : ofs_of(3)];
  assign cfg_misc  = active_q[ofs_of(4)+MISC_W-1  : ofs_of(4)];
endmodule

// File: rtl/mcr_chk.sv
module mcr_chk
  import mcr_pkg::*;
#(
  parameter int TOTAL = 76
) (
  input logic             clk,
  input logic             rst,
  input logic             chain_en,
  input logic             chain_in,
  input logic             chain_out,
  input logic             nb_sel_load,
  input logic [SEL_W-1:0] nb_sel,
  input logic             nb_strobe,
  input logic             nb_dout,
  input logic             commit,
  input logic [TOTAL-1:0] shadow,
  input logic [TOTAL-1:0] active,
  input logic [SEL_W-1:0] sel_q,
  input logic             sel_ok
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (active == '0 && shadow == '0 && !nb_dout && !sel_ok && !chain_out));

  a_r2_chain_shift: assert property (@(posedge clk) disable iff (rst)
    chain_en |=> shadow == {$past(shadow[TOTAL-2:0]), $past(chain_in)});

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(active));

  a_r10_commit_pre_shift: assert property (@(posedge clk) disable iff (rst)
    commit |=> active == $past(shadow));

  a_r5_bad_sel: assert property (@(posedge clk) disable iff (rst)
    (nb_sel_load && nb_sel >= SEL_W'(NBLK)) |=> ($stable(sel_q) && $stable(sel_ok)));

  a_r6_no_target: assert property (@(posedge clk) disable iff (rst)
    (!sel_ok && !chain_en) |=> $stable(shadow));

  a_r8_dout_hold: assert property (@(posedge clk) disable iff (rst)
    !nb_strobe |=> $stable(nb_dout));

  a_r9_chain_first: assert property (@(posedge clk) disable iff (rst)
    (chain_en && nb_strobe) |=> $stable(nb_dout));
endmodule

bind molecule_cfg_reg mcr_chk #(.TOTAL(TOTAL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chain_en    (chain_en),
  .chain_in    (chain_in),
  .chain_out   (chain_out),
  .nb_sel_load (nb_sel_load),
  .nb_sel      (nb_sel),
  .nb_strobe   (nb_strobe),
  .nb_dout     (nb_dout),
  .commit      (commit),
  .shadow      (shadow),
  .active      (active_q),
  .sel_q       (sel_q),
  .sel_ok      (sel_ok)
);

// File: tb/test_molecule_cfg_reg.sv
module test_molecule_cfg_reg;
  localparam int CLK_PERIOD = 10;
  localparam int TOTAL = 76;

  logic clk = 1'b0;
  logic rst;
  logic chain_en, chain_in, chain_out;
  logic nb_sel_load, nb_strobe, nb_din, nb_dout, commit;
  logic [2:0]  nb_sel;
  logic [3:0]  cfg_mode;
  logic [15:0] cfg_lut, cfg_lutin, cfg_misc;
  logic [23:0] cfg_swbox;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model, built from the requirements.
  logic [TOTAL-1:0] m_sh, m_act;
  logic             m_dout;
  int               m_sel;
  bit               m_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  molecule_cfg_reg i_molecule_cfg_reg (
    .clk(clk), .rst(rst), .chain_en(chain_en), .chain_in(chain_in),
    .chain_out(chain_out), .nb_sel_load(nb_sel_load), .nb_sel(nb_sel),
    .nb_strobe(nb_strobe), .nb_din(nb_din), .nb_dout(nb_dout),
    .commit(commit), .cfg_mode(cfg_mode), .cfg_lut(cfg_lut),
    .cfg_lutin(cfg_lutin), .cfg_swbox(cfg_swbox), .cfg_misc(cfg_misc)
  );

  // Width and offset of each block code (0 mode .. 4 misc).
  function automatic int blk_w(input int b);
    case (b)
      0: return 4;
      1: return 16;
      2: return 16;
      3: return 24;
      default: return 16;
    endcase
  endfunction

  function automatic int blk_lo(input int b);
    int s = 0;
    for (int j = b + 1; j < 5; j++) s += blk_w(j);
    return s;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "chain_out", TOTAL'(chain_out), TOTAL'(m_sh[TOTAL-1]));
    chk(tag, "nb_dout", TOTAL'(nb_dout), TOTAL'(m_dout));
    chk(tag, "fields", {cfg_mode, cfg_lut, cfg_lutin, cfg_swbox, cfg_misc}, m_act);
  endtask

  // Called at a falling edge: drive, pass one rising edge, update model, compare.
  task automatic step(input bit ce, input bit ci, input bit sl, input int sv,
                      input bit st, input bit di, input bit cm, input string tag);
    logic [TOTAL-1:0] old;
    int lo, w;
    chain_en = ce; chain_in = ci; nb_sel_load = sl; nb_sel = 3'(sv);
    nb_strobe = st; nb_din = di; commit = cm;
    @(posedge clk);
    old = m_sh;
    if (cm) m_act = old;
    if (ce) begin
      m_sh = {old[TOTAL-2:0], ci};
    end else if (st && m_ok) begin
      lo = blk_lo(m_sel); w = blk_w(m_sel);
      m_dout = old[lo+w-1];
      for (int k = w - 1; k > 0; k--) m_sh[lo+k] = old[lo+k-1];
      m_sh[lo] = di;
    end
    if (sl && sv < 5) begin m_sel = sv; m_ok = 1'b1; end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [TOTAL-1:0] word;
    logic [15:0] rb;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    chain_en = 0; chain_in = 0; nb_sel_load = 0; nb_sel = 0;
    nb_strobe = 0; nb_din = 0; commit = 0;
    m_sh = '0; m_act = '0; m_dout = 0; m_sel = 0; m_ok = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1");

    // R6: strobes with no target leave everything alone.
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 1, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, "R6");

    // R2: full chain load of a random word, then commit (R3).
    word = {$urandom(), $urandom(), $urandom()};
    for (int i = TOTAL - 1; i >= 0; i--) step(1, word[i], 0, 0, 0, 0, 0, "R2");
    chk("R2", "word", m_sh, word);
    idle("R3");
    step(0, 0, 0, 0, 0, 0, 1, "R3");
    chk("R3", "fields", {cfg_mode, cfg_lut, cfg_lutin, cfg_swbox, cfg_misc}, word);

    // R4 R7 R8: select lut (code 1), shift in 16 new bits, read back old.
    step(0, 0, 1, 1, 0, 0, 0, "R4");
    rb = '0;
    for (int i = 15; i >= 0; i--) begin
      step(0, 0, 0, 0, 1, i[0], 0, "R7");
      rb[i] = nb_dout;
    end
    chk("R8", "readback", TOTAL'(rb), TOTAL'(word[blk_lo(1)+15 -: 16]));
    step(0, 0, 0, 0, 0, 0, 1, "R7");

    // R5: bad codes keep lut selected.
    for (int c = 5; c < 8; c++) step(0, 0, 1, c, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 1, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 1, "R5");

    // R9: chain and strobe together.
    step(0, 0, 1, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 1, 0, 0, "R9");
    step(1, 0, 0, 0, 1, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 1, "R9");

    // R10: commit on the same edge as a local shift.
    step(0, 0, 1, 3, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 1, 1, "R10");
    step(0, 0, 0, 0, 0, 0, 1, "R10");

    // Random mix.
    for (int n = 0; n < 3000; n++) begin
      bit ce, sl, st, cm;
      ce = ($urandom_range(0, 7) == 0);
      sl = ($urandom_range(0, 9) == 0);
      st = ($urandom_range(0, 1) == 1);
      cm = ($urandom_range(0, 5) == 0);
      step(ce, 1'($urandom()), sl, $urandom_range(0, 7), st, 1'($urandom()), cm,
           "R7/R8/R9 random");
    end

    // R1: reset again mid-run.
    rst = 1'b1;
    @(posedge clk);
    m_sh = '0; m_act = '0; m_dout = 0; m_ok = 0; m_sel = 0;
    @(negedge clk);
    rst = 1'b0;
    compare("R1");
    step(0, 0, 0, 0, 1, 1, 1, "R6");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule